// File: doc/BRIEF.md
# Decoded Micro-op Cache

This block sits in front of the instruction decoder. It holds groups of already-decoded micro-ops, and each group is keyed by its fetch-block address. Every fetch address is presented to the lookup port before decode starts. The response comes back one cycle later.

On a hit, the cache supplies the stored micro-ops and their count to the rest of the pipeline. It also raises a sleep signal so the legacy decode path can be powered down for that fetch. On a miss, the decoder runs as usual. Every group the decoder emits comes back through the fill port and is written in without any selection policy.

The organisation is direct mapped: 256 lines, each holding up to 6 micro-ops, for 1536 micro-op slots in total. The low 8 bits of the fetch-block address pick the line, and the upper 12 bits form the tag. The cache must stay a subset of the instruction cache. One instruction-cache line covers two consecutive fetch blocks. When the instruction cache evicts a line, it reports that line on the invalidate port, and the matching micro-op lines are dropped.

Top module: `uopc_top`

## Requirements
- R1: After reset every line is invalid. Every lookup misses, and rsp_valid_o, rsp_hit_o and dec_sleep_o are low until a lookup is made.
- R2: A lookup presented in cycle t gets its response in cycle t+1. rsp_valid_o is high in exactly the cycles that follow a lookup.
- R3: A hit occurs when the line at index lk_addr_i[7:0] is valid and its stored tag equals lk_addr_i[19:8]. A hit returns the stored count on rsp_cnt_o and the stored micro-ops on rsp_uops_o, with slot k at bits [16k+15:16k]. Slots at or above the count read zero.
- R4: dec_sleep_o is high in exactly the response cycles that report a hit.
- R5: A miss response has rsp_hit_o=0, rsp_cnt_o=0 and rsp_uops_o=0.
- R6: Every fill whose count is between 1 and 6 is written. It overwrites whatever line its index held, so a different tag at the same index evicts the older line.
- R7: A fill count above 6 is stored as 6. A fill with count 0 is ignored and leaves the line unchanged.
- R8: If a lookup and a fill target the same index in the same cycle, the lookup returns a miss and the fill still completes.
- R9: inv_line_i carries a fetch-block address shifted right by one bit. It clears the valid lines at the two indices it covers whose tag matches, and leaves all other lines untouched. A lookup made in the same cycle as an invalidation that covers its index returns a miss.
- R10: If a fill and an invalidation covering the fill's address happen in the same cycle, the line ends up invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 20 | Fetch-block address being looked up |
| fill_valid_i | input | 1 | Decoder output group is present |
| fill_addr_i | input | 20 | Fetch-block address of the decoded group |
| fill_cnt_i | input | 3 | Number of micro-ops in the group |
| fill_uops_i | input | 96 | Six 16-bit micro-op slots |
| inv_valid_i | input | 1 | Instruction-cache eviction notice |
| inv_line_i | input | 19 | Evicted instruction-cache line (fetch-block address >> 1) |
| rsp_valid_o | output | 1 | Response for last cycle's lookup |
| rsp_hit_o | output | 1 | Response is a hit |
| rsp_cnt_o | output | 3 | Micro-op count on a hit |
| rsp_uops_o | output | 96 | Micro-op slots on a hit |
| dec_sleep_o | output | 1 | Power-down request for the decode path |

## Verification
The bench targets addresses that share an index but differ in tag. A design that compared only the index would return a stale group where a miss is expected.

It issues fills with count 0 and count 7. A design without the ignore or the clamp would expose garbage slots or an out-of-range count.

It drives a lookup and a fill to the same index in one cycle, and separately a lookup together with an invalidation. A design that forwarded or raced the write would report a hit in the hazard cycle. It also checks that a fill arriving in the same cycle as the eviction of its own instruction-cache line does not survive. A design that gave the fill priority would break inclusion.

// File: rtl/uopc_pkg.sv
package uopc_pkg;
  localparam int FA_W   = 20;
  localparam int IDX_W  = 8;
  localparam int LINES  = 1 << IDX_W;
  localparam int TAG_W  = FA_W - IDX_W;
  localparam int SLOTS  = 6;
  localparam int UOP_W  = 16;
  localparam int CNT_W  = 3;
  localparam int SPAN_W = 1;
  localparam int IL_W   = FA_W - SPAN_W;
  localparam int BUS_W  = SLOTS * UOP_W;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
    logic [CNT_W-1:0] cnt;
    logic [BUS_W-1:0] uops;
  } line_t;

  function automatic logic [IDX_W-1:0] idx_of(input logic [FA_W-1:0] fa);
    return fa[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [FA_W-1:0] fa);
    return fa[FA_W-1:IDX_W];
  endfunction

  function automatic logic inv_covers(input logic [IL_W-1:0] il, input logic [IDX_W-1:0] idx);
    return il[IDX_W-SPAN_W-1:0] == idx[IDX_W-1:SPAN_W];
  endfunction

  function automatic logic [TAG_W-1:0] inv_tag(input logic [IL_W-1:0] il);
    return il[IL_W-1:IDX_W-SPAN_W];
  endfunction

  function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] c);
    return (int'(c) > SLOTS) ? CNT_W'(SLOTS) : c;
  endfunction

  function automatic logic [BUS_W-1:0] mask_uops(input logic [BUS_W-1:0] u, input logic [CNT_W-1:0] c);
    logic [BUS_W-1:0] r;
    r = u;
    for (int k = 0; k < SLOTS; k++) begin
      if (k >= int'(c)) r[k*UOP_W +: UOP_W] = '0;
    end
    return r;
  endfunction
endpackage

// File: rtl/uopc_store.sv
module uopc_store
  import uopc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_we_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  line_t            fill_line_i,
  input  logic             inv_valid_i,
  input  logic [IL_W-1:0]  inv_line_i,
  output line_t            lines_o [LINES]
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    line_t cur_q;
    line_t nxt;
    logic  kill;

    always_comb begin
      nxt = cur_q;
      if (fill_we_i && fill_idx_i == MY_IDX) nxt = fill_line_i;
      kill = inv_valid_i && inv_covers(inv_line_i, MY_IDX) &&
             nxt.tag == inv_tag(inv_line_i);
      if (kill) nxt.vld = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cur_q.vld <= 1'b0;
      else        cur_q     <= nxt;
    end

    assign lines_o[g] = cur_q;
  end
endmodule

// File: rtl/uopc_lookup.sv
module uopc_lookup
  import uopc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid_i,
  input  logic [FA_W-1:0]  lk_addr_i,
  input  line_t            rd_line_i,
  input  logic             fill_we_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic             inv_valid_i,
  input  logic [IL_W-1:0]  inv_line_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [CNT_W-1:0] rsp_cnt_o,
  output logic [BUS_W-1:0] rsp_uops_o,
  output logic             sleep_o,
  output logic             collide_o
);
  logic [IDX_W-1:0] idx;
  logic             tag_eq;
  logic             hit_now;

  always_comb begin
    idx       = idx_of(lk_addr_i);
    tag_eq    = rd_line_i.vld && rd_line_i.tag == tag_of(lk_addr_i);
    collide_o = (fill_we_i && fill_idx_i == idx) ||
                (inv_valid_i && inv_covers(inv_line_i, idx));
    hit_now   = lk_valid_i && tag_eq && !collide_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_cnt_o   <= '0;
      rsp_uops_o  <= '0;
      sleep_o     <= 1'b0;
    end else begin
      rsp_valid_o <= lk_valid_i;
      rsp_hit_o   <= hit_now;
      sleep_o     <= hit_now;
      rsp_cnt_o   <= hit_now ? rd_line_i.cnt : '0;
      rsp_uops_o  <= hit_now ? rd_line_i.uops : '0;
    end
  end
endmodule

// File: rtl/uopc_top.sv
module uopc_top
  import uopc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid_i,
  input  logic [FA_W-1:0]  lk_addr_i,
  input  logic             fill_valid_i,
  input  logic [FA_W-1:0]  fill_addr_i,
  input  logic [CNT_W-1:0] fill_cnt_i,
  input  logic [BUS_W-1:0] fill_uops_i,
  input  logic             inv_valid_i,
  input  logic [IL_W-1:0]  inv_line_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [CNT_W-1:0] rsp_cnt_o,
  output logic [BUS_W-1:0] rsp_uops_o,
  output logic             dec_sleep_o
);
  line_t            lines [LINES];
  line_t            fill_line;
  line_t            rd_line;
  logic             fill_we;
  logic [IDX_W-1:0] fill_idx;
  logic             lk_collide;

  always_comb begin
    fill_we        = fill_valid_i && fill_cnt_i != '0;
    fill_idx       = idx_of(fill_addr_i);
    fill_line.vld  = 1'b1;
    fill_line.tag  = tag_of(fill_addr_i);
    fill_line.cnt  = clamp_cnt(fill_cnt_i);
    fill_line.uops = mask_uops(fill_uops_i, clamp_cnt(fill_cnt_i));
  end

  uopc_store u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_we_i   (fill_we),
    .fill_idx_i  (fill_idx),
    .fill_line_i (fill_line),
    .inv_valid_i (inv_valid_i),
    .inv_line_i  (inv_line_i),
    .lines_o     (lines)
  );

  assign rd_line = lines[idx_of(lk_addr_i)];

  uopc_lookup u_lookup (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid_i  (lk_valid_i),
    .lk_addr_i   (lk_addr_i),
    .rd_line_i   (rd_line),
    .fill_we_i   (fill_we),
    .fill_idx_i  (fill_idx),
    .inv_valid_i (inv_valid_i),
    .inv_line_i  (inv_line_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_hit_o   (rsp_hit_o),
    .rsp_cnt_o   (rsp_cnt_o),
    .rsp_uops_o  (rsp_uops_o),
    .sleep_o     (dec_sleep_o),
    .collide_o   (lk_collide)
  );
endmodule

// File: rtl/uopc_chk.sv
module uopc_chk
  import uopc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid_i,
  input logic             rsp_valid_o,
  input logic             rsp_hit_o,
  input logic [CNT_W-1:0] rsp_cnt_o,
  input logic [BUS_W-1:0] rsp_uops_o,
  input logic             dec_sleep_o,
  input logic             lk_collide
);
  AST_RSP_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid_i |=> rsp_valid_o); // R2
  AST_NO_RSP_WITHOUT_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid_i |=> !rsp_valid_o); // R2
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit_o |-> rsp_valid_o); // R3
  AST_SLEEP_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_sleep_o == (rsp_valid_o && rsp_hit_o)); // R4
  AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit_o |-> (rsp_cnt_o == '0 && rsp_uops_o == '0)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rsp_cnt_o) <= SLOTS); // R7
  AST_HAZARD_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid_i && lk_collide) |=> !rsp_hit_o); // R8
endmodule

bind uopc_top uopc_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid_i  (lk_valid_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_cnt_o   (rsp_cnt_o),
  .rsp_uops_o  (rsp_uops_o),
  .dec_sleep_o (dec_sleep_o),
  .lk_collide  (lk_collide)
);

// File: tb/uopc_top_tb_top.sv
module uopc_top_tb_top;
  import uopc_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             lk_valid_i;
  logic [FA_W-1:0]  lk_addr_i;
  logic             fill_valid_i;
  logic [FA_W-1:0]  fill_addr_i;
  logic [CNT_W-1:0] fill_cnt_i;
  logic [BUS_W-1:0] fill_uops_i;
  logic             inv_valid_i;
  logic [IL_W-1:0]  inv_line_i;
  logic             rsp_valid_o;
  logic             rsp_hit_o;
  logic [CNT_W-1:0] rsp_cnt_o;
  logic [BUS_W-1:0] rsp_uops_o;
  logic             dec_sleep_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  uopc_top dut_i (.*);

  typedef struct packed {
    logic [1:0]  op;      // 0 fill, 1 lookup, 2 invalidate
    logic [19:0] addr;
    logic [2:0]  cnt;
    logic [7:0]  seed;
    logic        exp_hit;
    logic [2:0]  exp_cnt;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 20'h01234, 3'd0, 8'h00, 1'b0, 3'd0},  // R1 R5 empty
    '{2'd0, 20'h01234, 3'd3, 8'h11, 1'b0, 3'd0},
    '{2'd1, 20'h01234, 3'd0, 8'h11, 1'b1, 3'd3},  // R3 R4
    '{2'd1, 20'h05634, 3'd0, 8'h00, 1'b0, 3'd0},  // R3 tag differs
    '{2'd0, 20'h05634, 3'd6, 8'h22, 1'b0, 3'd0},
    '{2'd1, 20'h05634, 3'd0, 8'h22, 1'b1, 3'd6},  // R6
    '{2'd1, 20'h01234, 3'd0, 8'h00, 1'b0, 3'd0},  // R6 evicted
    '{2'd0, 20'h01235, 3'd7, 8'h33, 1'b0, 3'd0},
    '{2'd1, 20'h01235, 3'd0, 8'h33, 1'b1, 3'd6},  // R7 clamp
    '{2'd0, 20'h00100, 3'd0, 8'h44, 1'b0, 3'd0},
    '{2'd1, 20'h00100, 3'd0, 8'h00, 1'b0, 3'd0},  // R7 zero count
    '{2'd0, 20'h00100, 3'd1, 8'h55, 1'b0, 3'd0},
    '{2'd1, 20'h00100, 3'd0, 8'h55, 1'b1, 3'd1},  // R6
    '{2'd0, 20'h01234, 3'd2, 8'h66, 1'b0, 3'd0},
    '{2'd2, 20'h01234, 3'd0, 8'h00, 1'b0, 3'd0},
    '{2'd1, 20'h01234, 3'd0, 8'h00, 1'b0, 3'd0},  // R9
    '{2'd1, 20'h01235, 3'd0, 8'h00, 1'b0, 3'd0},  // R9 partner
    '{2'd1, 20'h00100, 3'd0, 8'h55, 1'b1, 3'd1}   // R9 untouched
  };

  function automatic logic [BUS_W-1:0] pattern(input logic [7:0] seed);
    logic [BUS_W-1:0] r;
    for (int k = 0; k < SLOTS; k++) r[k*UOP_W +: UOP_W] = {seed, 8'(k + 1)};
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] expect_uops(input logic [7:0] seed, input int n);
    logic [BUS_W-1:0] r;
    r = '0;
    for (int k = 0; k < n; k++) r[k*UOP_W +: UOP_W] = {seed, 8'(k + 1)};
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_valid_i = 0; lk_addr_i = '0;
    fill_valid_i = 0; fill_addr_i = '0; fill_cnt_i = '0; fill_uops_i = '0;
    inv_valid_i = 0; inv_line_i = '0;
  endtask

  task automatic check_rsp(input string req, input bit hit, input int n, input logic [7:0] seed);
    check(rsp_valid_o == 1'b1, req, 128'(rsp_valid_o), 128'd1);
    check(rsp_hit_o == hit, req, 128'(rsp_hit_o), 128'(hit));
    check(dec_sleep_o == hit, {req, " R4 sleep"}, 128'(dec_sleep_o), 128'(hit));
    check(int'(rsp_cnt_o) == n, req, 128'(rsp_cnt_o), 128'(n));
    check(rsp_uops_o == expect_uops(seed, n), req, 128'(rsp_uops_o), 128'(expect_uops(seed, n)));
  endtask

  // drive one cycle starting after a falling edge, outputs sampled at next falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(rsp_valid_o == 0 && rsp_hit_o == 0 && dec_sleep_o == 0, "R1 reset outputs",
          128'({rsp_valid_o, rsp_hit_o, dec_sleep_o}), 128'd0);
    rst_n = 1;
    tick();
    check(rsp_valid_o == 0, "R2 idle", 128'(rsp_valid_o), 128'd0);

    for (int i = 0; i < NV; i++) begin
      idle_inputs();
      case (VECS[i].op)
        2'd0: begin
          fill_valid_i = 1; fill_addr_i = VECS[i].addr;
          fill_cnt_i = VECS[i].cnt; fill_uops_i = pattern(VECS[i].seed);
        end
        2'd1: begin lk_valid_i = 1; lk_addr_i = VECS[i].addr; end
        default: begin inv_valid_i = 1; inv_line_i = VECS[i].addr[FA_W-1:1]; end
      endcase
      tick();
      if (VECS[i].op == 2'd1)
        check_rsp($sformatf("R3 R5 R6 vec%0d", i), VECS[i].exp_hit, int'(VECS[i].exp_cnt), VECS[i].seed);
      else
        check(rsp_valid_o == 0, $sformatf("R2 vec%0d", i), 128'(rsp_valid_o), 128'd0);
    end

    // R8: lookup and fill to the same index together
    idle_inputs();
    fill_valid_i = 1; fill_addr_i = 20'h0AB40; fill_cnt_i = 3'd4; fill_uops_i = pattern(8'h77);
    lk_valid_i = 1; lk_addr_i = 20'h0AB40;
    tick();
    check_rsp("R8 hazard", 1'b0, 0, 8'h00);
    idle_inputs(); lk_valid_i = 1; lk_addr_i = 20'h0AB40;
    tick();
    check_rsp("R8 fill done", 1'b1, 4, 8'h77);

    // R9: lookup in same cycle as covering invalidation with other tag
    idle_inputs();
    fill_valid_i = 1; fill_addr_i = 20'h03051; fill_cnt_i = 3'd2; fill_uops_i = pattern(8'h88);
    tick();
    idle_inputs();
    inv_valid_i = 1; inv_line_i = 19'h07828;  // covers idx 50/51, tag 0F0
    lk_valid_i = 1; lk_addr_i = 20'h03051;
    tick();
    check_rsp("R9 inv hazard", 1'b0, 0, 8'h00);
    idle_inputs(); lk_valid_i = 1; lk_addr_i = 20'h03051;
    tick();
    check_rsp("R9 other tag kept", 1'b1, 2, 8'h88);

    // R10: fill and invalidation of its own line together
    idle_inputs();
    fill_valid_i = 1; fill_addr_i = 20'h04470; fill_cnt_i = 3'd5; fill_uops_i = pattern(8'h99);
    inv_valid_i = 1; inv_line_i = 19'h02238;
    tick();
    idle_inputs(); lk_valid_i = 1; lk_addr_i = 20'h04470;
    tick();
    check_rsp("R10 inclusion", 1'b0, 0, 8'h00);

    // R1: reset in mid-run clears lines
    idle_inputs();
    rst_n = 0;
    tick();
    rst_n = 1;
    lk_valid_i = 1; lk_addr_i = 20'h0AB40;
    tick();
    check_rsp("R1 after reset", 1'b0, 0, 8'h00);

    idle_inputs();
    tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule